// File: doc/BRIEF.md
# Maskable interrupt sampler and entry sequencer

This block stands beside the control logic of an 8-bit processor that runs on two non-overlapping clock phases. It watches an active-low maskable interrupt request pin and decides when a request is taken. When it takes a request, it drives the bus through the hardware interrupt entry sequence. It runs on a clock that ticks once per half-phase. The `phi2` input tells it which half the current tick belongs to. A processor cycle is one phase-1 half followed by one phase-2 half, and a cycle ends at the falling edge of phase 2.

The request pin feeds a latch. The latch tracks the pin during phase 2 and is isolated from the pin during phase 1, so the value it holds at the falling edge of phase 2 is the value used next. The core raises a poll strobe in the next-to-last cycle of each instruction and a second strobe in the T2 cycle of a branch. If the held request is low at a poll, the interrupt-disable flag is clear and no entry is under way, the sequencer runs seven bus cycles:
- two reads at the current PC,
- three pushes (PC high, PC low, status) into page one,
- two reads of the vector.

It then returns the new PC, the lowered stack pointer and a one-cycle completion pulse.

Top module: `irq_entry_unit`

## Requirements
- R1: While `rst` is high and on the cycle after it, `rw` is 1, `busy`, `done` and `iflag_set` are 0, and the latch holds "no request".
- R2: The latch takes the pin level only at the end of a phase-2 half (a tick with `phi2`=1). A low pin during a phase-1 half alone never starts an entry.
- R3: A request held low across the end of phase 2 and into the next phase-1 half is recognised at a poll in that next cycle. The entry starts in the cycle after the poll cycle.
- R4: A request is acted on only in a cycle with `poll_t0` or `poll_br` high, sampled in its phase-1 half. Without a strobe a low request starts nothing.
- R5: While `iflag` is 1 a poll is ignored. After `iflag` returns to 0, a later poll with the request still low starts the entry.
- R6: Entry cycles 1 and 2 are reads (`rw`=1) with `addr` equal to the PC captured at entry.
- R7: Entry cycles 3, 4 and 5 are writes (`rw`=0) at 0x0100+S, 0x0100+S-1 and 0x0100+S-2, with the low byte wrapping within page one. They carry PC[15:8], then PC[7:0], then the status byte.
- R8: The status byte pushed is `status_in` with bit 4 (break) forced to 0 and bit 5 forced to 1. For example, 0xB0 is pushed as 0xA0.
- R9: Entry cycles 6 and 7 read 0xFFFE and then 0xFFFF. `iflag_set` is 1 in exactly those two cycles.
- R10: In the cycle after entry cycle 7, `done` is 1 for one processor cycle, `busy` is 0, `pc_new` = {byte read at 0xFFFF, byte read at 0xFFFE} and `sp_out` = S-3 modulo 256.
- R11: `busy` is 1 for exactly the seven entry cycles and changes only at phase-2 ends. Polls during those cycles are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-phase clock |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | 1 while the current tick is a phase-2 half |
| irq_n | input | 1 | Raw active-low interrupt request pin |
| poll_t0 | input | 1 | Next-to-last-cycle poll strobe |
| poll_br | input | 1 | Branch T2 poll strobe |
| iflag | input | 1 | Interrupt-disable flag |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 8 | Current stack pointer |
| status_in | input | 8 | Current status byte |
| rdata | input | 8 | Read data from memory |
| addr | output | 16 | Address bus |
| wdata | output | 8 | Write data |
| rw | output | 1 | 1 = read, 0 = write |
| busy | output | 1 | Entry sequence under way |
| iflag_set | output | 1 | Set the interrupt-disable flag (vector cycles) |
| done | output | 1 | One-cycle completion pulse |
| pc_new | output | 16 | PC loaded from the vector |
| sp_out | output | 8 | Stack pointer after the three pushes |

## Verification
The bench sends a low pulse that covers only a phase-1 half. A design whose latch stayed transparent in phase 1 would start an entry that should not happen. It holds a request low across cycles that have no strobe, and under a set disable flag, to catch a sampler that polls at instruction end or ignores the mask. It then compares every one of the seven bus cycles against its own model and wraps the stack pointer at 0x01 to expose pushes that leave page one. It also keeps a poll strobe and a low request active through a whole entry, which shows whether a design restarts itself back-to-back.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam logic [DATA_W-1:0] STACK_PAGE = 8'h01;
    localparam int BRK_POS = 4;
    localparam int ONE_POS = 5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DUMMY0, ST_DUMMY1, ST_PUSH_HI,
        ST_PUSH_LO, ST_PUSH_P, ST_VEC_LO, ST_VEC_HI
    } entry_st_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] sp;
        logic [DATA_W-1:0] p;
    } snap_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              rw;
    } bus_t;

    function automatic logic [ADDR_W-1:0] stack_addr(input logic [DATA_W-1:0] sp);
        return {STACK_PAGE, sp};
    endfunction

    function automatic logic [DATA_W-1:0] hw_status(input logic [DATA_W-1:0] p);
        logic [DATA_W-1:0] r;
        r = p;
        r[BRK_POS] = 1'b0;
        r[ONE_POS] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/irq_pin_latch.sv
module irq_pin_latch (
    input  logic clk,
    input  logic rst,
    input  logic phi2,
    input  logic irq_n,
    output logic req
);
    logic held_n;

    always_ff @(posedge clk) begin
        if (rst)
            held_n <= 1'b1;
        else if (phi2)
            held_n <= irq_n;
    end

    assign req = ~held_n;
endmodule

// File: rtl/irq_poll_gate.sv
module irq_poll_gate (
    input  logic clk,
    input  logic rst,
    input  logic phi2,
    input  logic req,
    input  logic poll_t0,
    input  logic poll_br,
    input  logic iflag,
    input  logic busy,
    output logic take
);
    always_ff @(posedge clk) begin
        if (rst || phi2)
            take <= 1'b0;
        else
            take <= (poll_t0 | poll_br) & req & ~iflag & ~busy;
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phi2,
    input  logic              take,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] rdata,
    output bus_t              bus,
    output logic              busy,
    output logic              iflag_set,
    output logic              done,
    output logic [ADDR_W-1:0] pc_new,
    output logic [DATA_W-1:0] sp_out
);
    localparam logic [ADDR_W-1:0] VEC_HI_ADDR = VEC_ADDR + 1'b1;

    entry_st_e         st;
    snap_t             snap;
    logic [DATA_W-1:0] vec_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            snap   <= '0;
            vec_lo <= '0;
            done   <= 1'b0;
            pc_new <= '0;
            sp_out <= '0;
        end else if (phi2) begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (take) begin
                    st   <= ST_DUMMY0;
                    snap <= '{pc: pc_in, sp: sp_in, p: status_in};
                end
                ST_VEC_LO: begin
                    vec_lo <= rdata;
                    st     <= ST_VEC_HI;
                end
                ST_VEC_HI: begin
                    pc_new <= {rdata, vec_lo};
                    sp_out <= snap.sp - 8'd3;
                    done   <= 1'b1;
                    st     <= ST_IDLE;
                end
                default: st <= entry_st_e'(st + 3'd1);
            endcase
        end
    end

    always_comb begin
        bus       = '{addr: snap.pc, wdata: '0, rw: 1'b1};
        iflag_set = 1'b0;
        case (st)
            ST_PUSH_HI: bus = '{addr: stack_addr(snap.sp), wdata: snap.pc[15:8], rw: 1'b0};
            ST_PUSH_LO: bus = '{addr: stack_addr(snap.sp - 8'd1), wdata: snap.pc[7:0], rw: 1'b0};
            ST_PUSH_P:  bus = '{addr: stack_addr(snap.sp - 8'd2), wdata: hw_status(snap.p), rw: 1'b0};
            ST_VEC_LO: begin
                bus.addr  = VEC_ADDR;
                iflag_set = 1'b1;
            end
            ST_VEC_HI: begin
                bus.addr  = VEC_HI_ADDR;
                iflag_set = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy = (st != ST_IDLE);
endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
    import irq_entry_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phi2,
    input  logic              irq_n,
    input  logic              poll_t0,
    input  logic              poll_br,
    input  logic              iflag,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] sp_in,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              rw,
    output logic              busy,
    output logic              iflag_set,
    output logic              done,
    output logic [ADDR_W-1:0] pc_new,
    output logic [DATA_W-1:0] sp_out
);
    logic req;
    logic take;
    bus_t bus;

    irq_pin_latch u_latch (
        .clk(clk), .rst(rst), .phi2(phi2), .irq_n(irq_n), .req(req)
    );

    irq_poll_gate u_poll (
        .clk(clk), .rst(rst), .phi2(phi2), .req(req), .poll_t0(poll_t0),
        .poll_br(poll_br), .iflag(iflag), .busy(busy), .take(take)
    );

    irq_entry_seq #(.VEC_ADDR(VEC_ADDR)) u_seq (
        .clk(clk), .rst(rst), .phi2(phi2), .take(take), .pc_in(pc_in),
        .sp_in(sp_in), .status_in(status_in), .rdata(rdata), .bus(bus),
        .busy(busy), .iflag_set(iflag_set), .done(done), .pc_new(pc_new),
        .sp_out(sp_out)
    );

    assign addr  = bus.addr;
    assign wdata = bus.wdata;
    assign rw    = bus.rw;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk (
    input logic        clk,
    input logic        rst,
    input logic        phi2,
    input logic        req,
    input logic        busy,
    input logic        done,
    input logic        rw,
    input logic        iflag_set,
    input logic [15:0] addr
);
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (rw && !busy && !done && !iflag_set && !req));

    a_r2_latch_frozen_ph1: assert property (@(posedge clk) disable iff (rst)
        !phi2 |=> $stable(req));

    a_r7_writes_in_page1: assert property (@(posedge clk) disable iff (rst)
        !rw |-> (busy && addr[15:8] == 8'h01));

    a_r9_iflag_on_vector: assert property (@(posedge clk) disable iff (rst)
        iflag_set |-> (rw && busy && addr[15:1] == 15'h7FFF));

    a_r10_done_after_seq: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r11_busy_steps_ph2: assert property (@(posedge clk) disable iff (rst)
        !phi2 |=> $stable(busy));
endmodule

bind irq_entry_unit irq_entry_chk u_chk (
    .clk(clk), .rst(rst), .phi2(phi2), .req(req), .busy(busy), .done(done),
    .rw(rw), .iflag_set(iflag_set), .addr(addr)
);

// File: tb/irq_entry_unit_test.sv
module irq_entry_unit_test;
    localparam int PERIOD = 10;

    typedef struct {
        logic [15:0] addr;
        logic [7:0]  wd;
        logic        rw;
        logic        ifs;
        string       tag;
    } beat_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phi2 = 1'b0;
    logic        irq_n = 1'b1;
    logic        poll_t0 = 1'b0;
    logic        poll_br = 1'b0;
    logic        iflag = 1'b0;
    logic [15:0] pc_in = 16'h1234;
    logic [7:0]  sp_in = 8'hFD;
    logic [7:0]  status_in = 8'hB0;
    logic [7:0]  rdata;
    logic [15:0] addr, pc_new;
    logic [7:0]  wdata, sp_out;
    logic        rw, busy, iflag_set, done;

    logic [7:0]  vec_lo_b = 8'h80;
    logic [7:0]  vec_hi_b = 8'hC0;

    int          n_checks = 0;
    int          n_fails = 0;
    beat_t       exp_q[$];
    logic        m_lat = 1'b1;
    logic        exp_done = 1'b0;
    logic [15:0] exp_pc;
    logic [7:0]  exp_sp;
    string       idle_tag = "R1";

    always #(PERIOD/2) clk = ~clk;

    assign rdata = (addr == 16'hFFFE) ? vec_lo_b :
                   (addr == 16'hFFFF) ? vec_hi_b : 8'hEA;

    irq_entry_unit uut (
        .clk(clk), .rst(rst), .phi2(phi2), .irq_n(irq_n), .poll_t0(poll_t0),
        .poll_br(poll_br), .iflag(iflag), .pc_in(pc_in), .sp_in(sp_in),
        .status_in(status_in), .rdata(rdata), .addr(addr), .wdata(wdata),
        .rw(rw), .busy(busy), .iflag_set(iflag_set), .done(done),
        .pc_new(pc_new), .sp_out(sp_out)
    );

    task automatic chk(input logic ok, input string tag, input string msg);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    task automatic push_entry();
        logic [7:0] s;
        s = sp_in;
        exp_q.push_back('{pc_in, 8'h00, 1'b1, 1'b0, "R6"});
        exp_q.push_back('{pc_in, 8'h00, 1'b1, 1'b0, "R6"});
        exp_q.push_back('{{8'h01, s}, pc_in[15:8], 1'b0, 1'b0, "R7"});
        exp_q.push_back('{{8'h01, s - 8'd1}, pc_in[7:0], 1'b0, 1'b0, "R7"});
        exp_q.push_back('{{8'h01, s - 8'd2}, (status_in & 8'hEF) | 8'h20, 1'b0, 1'b0, "R8"});
        exp_q.push_back('{16'hFFFE, 8'h00, 1'b1, 1'b1, "R9"});
        exp_q.push_back('{16'hFFFF, 8'h00, 1'b1, 1'b1, "R9"});
        exp_pc = {vec_hi_b, vec_lo_b};
        exp_sp = s - 8'd3;
    endtask

    // One processor cycle: phase-1 half with pin p1, phase-2 half with pin p2.
    task automatic cyc(input logic p1, input logic p2, input logic t0, input logic br);
        logic was_seq;
        beat_t b;
        @(negedge clk);
        phi2 = 1'b0; irq_n = p1; poll_t0 = t0; poll_br = br;
        was_seq = 1'b0;
        // R10: completion pulse, vector PC and stack pointer
        chk(done == exp_done, "R10", $sformatf("done=%0b exp=%0b", done, exp_done));
        if (exp_done) begin
            chk(pc_new == exp_pc, "R10", $sformatf("pc_new=%h exp=%h", pc_new, exp_pc));
            chk(sp_out == exp_sp, "R10", $sformatf("sp_out=%h exp=%h", sp_out, exp_sp));
        end
        if (exp_q.size() > 0) begin
            b = exp_q.pop_front();
            was_seq = 1'b1;
            chk(busy && addr == b.addr && rw == b.rw && iflag_set == b.ifs &&
                (b.rw || wdata == b.wd), b.tag,
                $sformatf("busy=%0b addr=%h rw=%0b wd=%h ifs=%0b exp addr=%h rw=%0b wd=%h ifs=%0b",
                          busy, addr, rw, wdata, iflag_set, b.addr, b.rw, b.wd, b.ifs));
        end else begin
            chk(!busy && rw && !iflag_set, idle_tag,
                $sformatf("busy=%0b rw=%0b ifs=%0b exp 0/1/0", busy, rw, iflag_set));
        end
        exp_done = was_seq && (exp_q.size() == 0);
        if (!was_seq && (t0 || br) && !m_lat && !iflag)
            push_entry();
        @(negedge clk);
        phi2 = 1'b1; irq_n = p2;
        m_lat = p2;
    endtask

    task automatic run(input int n, input logic pin, input logic t0, input logic br);
        for (int i = 0; i < n; i++) cyc(pin, pin, t0, br);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); phi2 = ~phi2;
        end
        @(negedge clk); phi2 = 1'b0;
        rst = 1'b0;
        // R1: reset state
        chk(rw && !busy && !done && !iflag_set, "R1",
            $sformatf("rw=%0b busy=%0b done=%0b ifs=%0b exp 1/0/0/0", rw, busy, done, iflag_set));
        @(negedge clk); phi2 = 1'b1;

        // R2: low only in phase-1 half, polled -> nothing
        idle_tag = "R2";
        cyc(1'b0, 1'b1, 1'b1, 1'b0);
        cyc(1'b0, 1'b1, 1'b1, 1'b0);
        run(2, 1'b1, 1'b1, 1'b0);

        // R3: request straddling the end of phase 2
        idle_tag = "R3";
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b1, 1'b0);
        run(10, 1'b1, 1'b0, 1'b0);

        // R5: masked poll, then unmasked
        idle_tag = "R5";
        pc_in = 16'hA55A; sp_in = 8'h80; status_in = 8'hCF;
        vec_lo_b = 8'h34; vec_hi_b = 8'h12;
        iflag = 1'b1;
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        run(3, 1'b0, 1'b1, 1'b0);
        iflag = 1'b0;
        cyc(1'b0, 1'b1, 1'b1, 1'b0);
        run(10, 1'b1, 1'b0, 1'b0);

        // R4: low without strobes, then branch strobe
        idle_tag = "R4";
        pc_in = 16'h0F00; sp_in = 8'h10; status_in = 8'h00;
        vec_lo_b = 8'h00; vec_hi_b = 8'hE0;
        run(4, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0, 1'b1);
        run(10, 1'b1, 1'b0, 1'b0);

        // R11 with stack wrap: request and strobe held through the entry
        idle_tag = "R11";
        pc_in = 16'hBEEF; sp_in = 8'h01; status_in = 8'hFF;
        vec_lo_b = 8'h5A; vec_hi_b = 8'hA5;
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        run(8, 1'b0, 1'b1, 1'b0);
        run(6, 1'b1, 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule